// File: doc/BRIEF.md
# Single-Channel Memory-Mapped DMA Engine

This block is one DMA channel. Software sets it up through a window of four 32-bit registers: a source address, a destination address, a count of transfer cycles and a control word. Setting the enable bit starts the transfer. The channel moves data one element at a time over a simple request/acknowledge master port. For each element it reads from the source and then writes to the destination. After the element, each address moves by its own signed step. A 3-bit code picks that step, and a burst flag multiplies it by four.

The count is measured in cycles, not in bytes. One cycle carries one element, or four elements when burst mode is on. The remaining count can be read back while the channel runs. Each side can be paced by a peripheral request line, and the channel answers each completed cycle with a one-clock grant. When the channel finishes or hits an error, it sets a status bit. Software clears that bit by writing 0 to it. The interrupt output combines each status bit with its own enable bit.

Element data is carried right-justified on the master port. The element width is presented on `mst_size`, and bytes above the width are written as zero.

Top module: `dma_chan_engine`

## Requirements
- R1: Register selects: 0 source address, 1 destination address, 2 cycle count (24 bits, reads the remaining count), 3 control. Writes to selects 0–2, and to the control configuration fields, are ignored while enable (control bit 0) is 1.
- R2: Writing enable as 1 while the channel is idle and the count is 0 sets done status (bit 1) and leaves enable at 0, with no master access.
- R3: Each element is one read at the source address followed by one write at the destination address. The write data is the read data masked to the element width. `mst_size` carries the width field (bits 21:20): 00 word, 01 halfword, 10 byte. Request, address and direction are held until acknowledge.
- R4: With burst off (bit 3 = 0), the step codes (source in bits 10:8, destination in bits 14:12) mean: 000 → 0, 001 → +1, 010 → +2, 011 → +4, 101 → −1, 110 → −2, 111 → −4.
- R5: With burst on, one cycle carries four elements and every step magnitude is four times larger.
- R6: The count drops by one at the end of each cycle. When it reaches 0, the channel sets done status, clears enable and stops.
- R7: A nonzero request-line number (source in bits 27:24, destination in bits 19:16) makes each cycle wait until `periph_req` at that index is high. A line number of 0 means no wait.
- R8: When a cycle's last element completes, `periph_gnt` pulses for one clock at each nonzero line index, and at no other index.
- R9: An error response sets error status (bit 4), clears enable, leaves the count and the addresses unchanged, and ends master traffic.
- R10: Writing 0 to a status bit clears it. Writing 1 leaves it unchanged.
- R11: `irq` = (done status AND done interrupt enable, bit 2) OR (error status AND error interrupt enable, bit 5).
- R12: Writing enable as 0 during a transfer stops the channel. It makes no further accesses, even when its request lines later go high.
- R13: `mst_sys` shows control bit 6 during reads and control bit 7 during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_wr | input | 1 | register write strobe |
| cfg_sel | input | 2 | register select |
| cfg_wdata | input | 32 | register write data |
| cfg_rdata | output | 32 | register read data (combinational) |
| mst_req | output | 1 | master access request |
| mst_we | output | 1 | 1 = write, 0 = read |
| mst_sys | output | 1 | bus select of the current side |
| mst_addr | output | ADDR_W | access address |
| mst_size | output | 2 | element width code |
| mst_wdata | output | 32 | write data |
| mst_rdata | input | 32 | read data, valid with acknowledge |
| mst_ack | input | 1 | access complete |
| mst_err | input | 1 | error response, qualified by acknowledge |
| periph_req | input | 16 | peripheral request lines (index 0 unused) |
| periph_gnt | output | 16 | peripheral grant pulses |
| irq | output | 1 | interrupt |

## Verification
Transfers are run with three setups. The first uses word width with two different positive steps. The second uses byte width with two negative steps. The third uses burst halfword, with one side stepping up and the other stepping down. Together they separate a wrong sign, a wrong magnitude, a missing ×4 scaling and a wrong number of elements per cycle. Every access is compared with a queue of expected items, covering direction, address, width, bus select and data. Other runs stall the channel on a request line, inject an error on the first write, stop the channel mid-transfer, and start it with a zero count. These show that waits, aborts and immediate completion leave the count, the addresses and the bus idle exactly as the requirements say.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int LINE_W = 4;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [3:0] src_line;
        logic [1:0] width;
        logic [3:0] dst_line;
        logic [2:0] dst_code;
        logic [2:0] src_code;
        logic       dst_sys;
        logic       src_sys;
        logic       err_ie;
        logic       err_sts;
        logic       burst;
        logic       done_ie;
        logic       done_sts;
        logic       en;
    } ctrl_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_RD,
        S_WR
    } seq_state_t;

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.en;
        w[1]     = c.done_sts;
        w[2]     = c.done_ie;
        w[3]     = c.burst;
        w[4]     = c.err_sts;
        w[5]     = c.err_ie;
        w[6]     = c.src_sys;
        w[7]     = c.dst_sys;
        w[10:8]  = c.src_code;
        w[14:12] = c.dst_code;
        w[19:16] = c.dst_line;
        w[21:20] = c.width;
        w[27:24] = c.src_line;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [31:0] w);
        ctrl_t c;
        c.en       = w[0];
        c.done_sts = w[1];
        c.done_ie  = w[2];
        c.burst    = w[3];
        c.err_sts  = w[4];
        c.err_ie   = w[5];
        c.src_sys  = w[6];
        c.dst_sys  = w[7];
        c.src_code = w[10:8];
        c.dst_code = w[14:12];
        c.dst_line = w[19:16];
        c.width    = w[21:20];
        c.src_line = w[27:24];
        return c;
    endfunction

    // magnitude of the address step: 1/2/4, scaled x4 in burst mode
    function automatic logic [4:0] step_mag(logic [2:0] code, logic burst);
        logic [4:0] m;
        case (code[1:0])
            2'b01:   m = 5'd1;
            2'b10:   m = 5'd2;
            2'b11:   m = 5'd4;
            default: m = 5'd0;
        endcase
        return burst ? (m << 2) : m;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(logic [1:0] width);
        case (width)
            2'b01:   return 32'h0000_FFFF;
            2'b10:   return 32'h0000_00FF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        code,
    input  logic              burst,
    output logic [ADDR_W-1:0] next_addr
);
    import dma_pkg::*;

    logic [ADDR_W-1:0] mag;

    assign mag       = ADDR_W'(step_mag(code, burst));
    assign next_addr = code[2] ? (addr - mag) : (addr + mag);

endmodule

// File: rtl/dma_regs.sv
module dma_regs #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [1:0]          cfg_sel,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                adv,
    input  logic                cyc_dec,
    input  logic                fin_ok,
    input  logic                fin_err,
    output dma_pkg::ctrl_t      ctrl,
    output logic [ADDR_W-1:0]   src_addr,
    output logic [ADDR_W-1:0]   dst_addr,
    output logic [CNT_W-1:0]    count,
    output logic                irq
);
    import dma_pkg::*;

    ctrl_t             ctrl_q;
    ctrl_t             wctrl;
    logic [ADDR_W-1:0] src_q, dst_q, src_nx, dst_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy;

    assign wctrl = word_to_ctrl(cfg_wdata);
    assign busy  = ctrl_q.en;

    dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
        .addr(src_q), .code(ctrl_q.src_code), .burst(ctrl_q.burst), .next_addr(src_nx)
    );
    dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
        .addr(dst_q), .code(ctrl_q.dst_code), .burst(ctrl_q.burst), .next_addr(dst_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (cfg_wr) begin
                case (cfg_sel)
                    2'd0: if (!busy) src_q <= cfg_wdata[ADDR_W-1:0];
                    2'd1: if (!busy) dst_q <= cfg_wdata[ADDR_W-1:0];
                    2'd2: if (!busy) cnt_q <= cfg_wdata[CNT_W-1:0];
                    default: begin
                        if (!busy) begin
                            ctrl_q.src_line <= wctrl.src_line;
                            ctrl_q.dst_line <= wctrl.dst_line;
                            ctrl_q.width    <= wctrl.width;
                            ctrl_q.src_code <= wctrl.src_code;
                            ctrl_q.dst_code <= wctrl.dst_code;
                            ctrl_q.src_sys  <= wctrl.src_sys;
                            ctrl_q.dst_sys  <= wctrl.dst_sys;
                            ctrl_q.burst    <= wctrl.burst;
                        end
                        ctrl_q.done_ie  <= wctrl.done_ie;
                        ctrl_q.err_ie   <= wctrl.err_ie;
                        ctrl_q.done_sts <= ctrl_q.done_sts & wctrl.done_sts;
                        ctrl_q.err_sts  <= ctrl_q.err_sts & wctrl.err_sts;
                        if (!wctrl.en) begin
                            ctrl_q.en <= 1'b0;
                        end else if (!busy) begin
                            if (cnt_q == '0) begin
                                ctrl_q.en       <= 1'b0;
                                ctrl_q.done_sts <= 1'b1;
                            end else begin
                                ctrl_q.en <= 1'b1;
                            end
                        end
                    end
                endcase
            end
            if (adv) begin
                src_q <= src_nx;
                dst_q <= dst_nx;
            end
            if (cyc_dec) cnt_q <= cnt_q - CNT_W'(1);
            if (fin_ok) begin
                ctrl_q.en       <= 1'b0;
                ctrl_q.done_sts <= 1'b1;
            end
            if (fin_err) begin
                ctrl_q.en      <= 1'b0;
                ctrl_q.err_sts <= 1'b1;
            end
        end
    end

    always_comb begin
        case (cfg_sel)
            2'd0:    cfg_rdata = 32'(src_q);
            2'd1:    cfg_rdata = 32'(dst_q);
            2'd2:    cfg_rdata = 32'(cnt_q);
            default: cfg_rdata = ctrl_to_word(ctrl_q);
        endcase
    end

    assign irq      = (ctrl_q.done_sts & ctrl_q.done_ie) | (ctrl_q.err_sts & ctrl_q.err_ie);
    assign ctrl     = ctrl_q;
    assign src_addr = src_q;
    assign dst_addr = dst_q;
    assign count    = cnt_q;

    // R6
    count_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.en |=> (cnt_q <= $past(cnt_q)));

    // R9
    count_frozen_err_chk: assert property (@(posedge clk) disable iff (rst)
        fin_err |=> (cnt_q == $past(cnt_q)) && !ctrl_q.en && ctrl_q.err_sts);

    // R2
    zero_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_sel == 2'd3 && wctrl.en && !ctrl_q.en && cnt_q == '0)
        |=> (ctrl_q.done_sts && !ctrl_q.en));

endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  dma_pkg::ctrl_t      ctrl,
    input  logic [ADDR_W-1:0]   src_addr,
    input  logic [ADDR_W-1:0]   dst_addr,
    input  logic [CNT_W-1:0]    count,
    output logic                mst_req,
    output logic                mst_we,
    output logic                mst_sys,
    output logic [ADDR_W-1:0]   mst_addr,
    output logic [1:0]          mst_size,
    output logic [31:0]         mst_wdata,
    input  logic [31:0]         mst_rdata,
    input  logic                mst_ack,
    input  logic                mst_err,
    input  logic [(1<<dma_pkg::LINE_W)-1:0] periph_req,
    output logic [(1<<dma_pkg::LINE_W)-1:0] periph_gnt,
    output logic                adv,
    output logic                cyc_dec,
    output logic                fin_ok,
    output logic                fin_err
);
    import dma_pkg::*;

    localparam int LINES = 1 << LINE_W;

    seq_state_t       state_q, state_d;
    logic [1:0]       elem_q;
    logic [31:0]      data_q;
    logic [LINES-1:0] gnt_q;
    logic             src_ok, dst_ok, last_elem, cyc_end;

    assign src_ok    = (ctrl.src_line == '0) || periph_req[ctrl.src_line];
    assign dst_ok    = (ctrl.dst_line == '0) || periph_req[ctrl.dst_line];
    assign last_elem = ctrl.burst ? (elem_q == 2'd3) : (elem_q == 2'd0);

    assign mst_req   = (state_q == S_RD) || (state_q == S_WR);
    assign mst_we    = (state_q == S_WR);
    assign mst_sys   = (state_q == S_WR) ? ctrl.dst_sys : ctrl.src_sys;
    assign mst_addr  = (state_q == S_WR) ? dst_addr : src_addr;
    assign mst_size  = ctrl.width;
    assign mst_wdata = data_q;

    always_comb begin
        state_d = state_q;
        adv     = 1'b0;
        cyc_end = 1'b0;
        fin_ok  = 1'b0;
        fin_err = 1'b0;
        case (state_q)
            S_IDLE: if (ctrl.en) state_d = S_WAIT;
            S_WAIT: begin
                if (!ctrl.en)             state_d = S_IDLE;
                else if (src_ok && dst_ok) state_d = S_RD;
            end
            S_RD: begin
                if (mst_ack) begin
                    if (mst_err) begin
                        fin_err = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        state_d = S_WR;
                    end
                end
            end
            S_WR: begin
                if (mst_ack) begin
                    if (mst_err) begin
                        fin_err = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        adv = 1'b1;
                        if (last_elem) begin
                            cyc_end = 1'b1;
                            if (count == CNT_W'(1)) begin
                                fin_ok  = 1'b1;
                                state_d = S_IDLE;
                            end else begin
                                state_d = S_WAIT;
                            end
                        end else begin
                            state_d = ctrl.en ? S_RD : S_IDLE;
                        end
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign cyc_dec = cyc_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            elem_q  <= '0;
            data_q  <= '0;
            gnt_q   <= '0;
        end else begin
            state_q <= state_d;
            gnt_q   <= '0;
            if (state_q == S_WAIT) elem_q <= '0;
            if (state_q == S_RD && mst_ack && !mst_err)
                data_q <= mst_rdata & lane_mask(ctrl.width);
            if (adv) elem_q <= elem_q + 2'd1;
            if (cyc_end) begin
                if (ctrl.src_line != '0) gnt_q[ctrl.src_line] <= 1'b1;
                if (ctrl.dst_line != '0) gnt_q[ctrl.dst_line] <= 1'b1;
            end
        end
    end

    assign periph_gnt = gnt_q;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mst_req && !mst_ack) |=> (mst_req && $stable(mst_addr) && $stable(mst_we)));

    // R8
    gnt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (|periph_gnt) |=> !(|periph_gnt));

    // R8
    gnt_count_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(periph_gnt) <= 2) && !periph_gnt[0]);

    // R9
    err_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (mst_req && mst_ack && mst_err) |=> !mst_req);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    output logic               mst_req,
    output logic               mst_we,
    output logic               mst_sys,
    output logic [ADDR_W-1:0]  mst_addr,
    output logic [1:0]         mst_size,
    output logic [31:0]        mst_wdata,
    input  logic [31:0]        mst_rdata,
    input  logic               mst_ack,
    input  logic               mst_err,
    input  logic [15:0]        periph_req,
    output logic [15:0]        periph_gnt,
    output logic               irq
);
    import dma_pkg::*;

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [CNT_W-1:0]  count;
    logic              adv, cyc_dec, fin_ok, fin_err;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .adv(adv), .cyc_dec(cyc_dec), .fin_ok(fin_ok), .fin_err(fin_err),
        .ctrl(ctrl), .src_addr(src_addr), .dst_addr(dst_addr), .count(count), .irq(irq)
    );

    dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst),
        .ctrl(ctrl), .src_addr(src_addr), .dst_addr(dst_addr), .count(count),
        .mst_req(mst_req), .mst_we(mst_we), .mst_sys(mst_sys), .mst_addr(mst_addr),
        .mst_size(mst_size), .mst_wdata(mst_wdata), .mst_rdata(mst_rdata),
        .mst_ack(mst_ack), .mst_err(mst_err),
        .periph_req(periph_req), .periph_gnt(periph_gnt),
        .adv(adv), .cyc_dec(cyc_dec), .fin_ok(fin_ok), .fin_err(fin_err)
    );

endmodule

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        sys;
        logic [31:0] data;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mst_req, mst_we, mst_sys;
    logic [31:0] mst_addr, mst_wdata;
    logic [1:0]  mst_size;
    logic [31:0] mst_rdata = '0;
    logic        mst_ack = 1'b0;
    logic        mst_err = 1'b0;
    logic [15:0] periph_req = '0;
    logic [15:0] periph_gnt;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int n_acc = 0;
    int err_at = -1;
    int gnt_cnt [16];
    bit done_flag = 0;
    acc_t exp_q[$];

    always #2 clk = ~clk;

    dma_chan_engine uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mst_req(mst_req), .mst_we(mst_we), .mst_sys(mst_sys),
        .mst_addr(mst_addr), .mst_size(mst_size), .mst_wdata(mst_wdata),
        .mst_rdata(mst_rdata), .mst_ack(mst_ack), .mst_err(mst_err),
        .periph_req(periph_req), .periph_gnt(periph_gnt), .irq(irq)
    );

    function automatic logic [31:0] pat(logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction

    function automatic logic [31:0] wmask(logic [1:0] w);
        return (w == 2'b01) ? 32'h0000_FFFF : (w == 2'b10) ? 32'h0000_00FF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] ctl(bit en, bit die, bit burst, bit eie, bit ssys, bit dsys,
                                        int scode, int dcode, int dline, int width, int sline);
        return 32'(en) | (32'(die) << 2) | (32'(burst) << 3) | (32'(eie) << 5) |
               (32'(ssys) << 6) | (32'(dsys) << 7) | (32'(scode) << 8) | (32'(dcode) << 12) |
               (32'(dline) << 16) | (32'(width) << 20) | (32'(sline) << 24);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: serves master requests and compares to queue
    always @(negedge clk) begin
        for (int i = 0; i < 16; i++) if (periph_gnt[i]) gnt_cnt[i]++;
        if (mst_ack) begin
            mst_ack <= 1'b0;
            mst_err <= 1'b0;
        end else if (mst_req) begin
            acc_t e;
            n_acc++;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3 unexpected access actual=%h expected=none", mst_addr);
            end else begin
                e = exp_q.pop_front();
                if (mst_we !== e.we || mst_addr !== e.addr || mst_size !== e.size ||
                    mst_sys !== e.sys || (e.we && mst_wdata !== e.data)) begin
                    fails++;
                    $display("FAIL R3/R13 access actual=%b %h %h %b %h expected=%b %h %h %b %h",
                             mst_we, mst_addr, mst_size, mst_sys, mst_wdata,
                             e.we, e.addr, e.size, e.sys, e.data);
                end
            end
            mst_rdata <= pat(mst_addr);
            mst_err   <= (n_acc == err_at);
            mst_ack   <= 1'b1;
        end
    end

    task automatic wr_reg(int sel, logic [31:0] d);
        @(negedge clk);
        cfg_sel = 2'(sel); cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_reg(int sel, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = 2'(sel);
        #1 d = cfg_rdata;
    endtask

    task automatic push(bit we, logic [31:0] a, int size, bit sys, logic [31:0] d);
        acc_t e;
        e.we = we; e.addr = a; e.size = 2'(size); e.sys = sys; e.data = d;
        exp_q.push_back(e);
    endtask

    task automatic push_elem(logic [31:0] s, logic [31:0] d, int w, bit ssys, bit dsys);
        push(1'b0, s, w, ssys, 32'h0);
        push(1'b1, d, w, dsys, pat(s) & wmask(2'(w)));
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int i = 0; i < 3000; i++) begin
            rd_reg(3, c);
            if (!c[0]) break;
        end
    endtask

    task automatic setup(logic [31:0] s, logic [31:0] d, logic [31:0] n);
        wr_reg(0, s); wr_reg(1, d); wr_reg(2, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base;
        for (int i = 0; i < 16; i++) gnt_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int s = 0; s < 4; s++) begin rd_reg(s, v); check("R1 reset reg", v, 0); end
        check("R11 reset irq", 32'(irq), 0);

        // R1 readback
        setup(32'h1234_5678, 32'h9ABC_DEF0, 32'h00AB_CDEF);
        rd_reg(0, v); check("R1 src", v, 32'h1234_5678);
        rd_reg(1, v); check("R1 dst", v, 32'h9ABC_DEF0);
        rd_reg(2, v); check("R1 count", v, 32'h00AB_CDEF);

        // R2 zero-count start
        wr_reg(2, 0);
        base = n_acc;
        wr_reg(3, ctl(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        repeat (5) @(negedge clk);
        rd_reg(3, v); check("R2 done set, enable clear", v & 32'h3, 32'h2);
        check("R2 no access", 32'(n_acc - base), 0);
        check("R11 irq on done", 32'(irq), 1);
        wr_reg(3, ctl(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0) | 32'h2);
        rd_reg(3, v); check("R10 write 1 keeps done", 32'(v[1]), 1);
        wr_reg(3, ctl(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        rd_reg(3, v); check("R10 write 0 clears done", 32'(v[1]), 0);
        check("R11 irq cleared", 32'(irq), 0);

        // R4 R6 R13 word, steps +4 / +1
        setup(32'h1000, 32'h2000, 3);
        for (int i = 0; i < 3; i++) push_elem(32'h1000 + 4*i, 32'h2000 + i, 0, 1, 0);
        wr_reg(3, ctl(1, 1, 0, 0, 1, 0, 3, 1, 0, 0, 0));
        wait_idle();
        check("R3 all word accesses", 32'(exp_q.size()), 0);
        rd_reg(2, v); check("R6 count zero", v, 0);
        rd_reg(0, v); check("R4 src +4 steps", v, 32'h100C);
        rd_reg(1, v); check("R4 dst +1 steps", v, 32'h2003);
        rd_reg(3, v); check("R6 done set", v & 32'h3, 32'h2);
        check("R11 irq done", 32'(irq), 1);
        wr_reg(3, 0);

        // R4 byte, steps -4 / -2
        setup(32'h3000, 32'h4000, 2);
        push_elem(32'h3000, 32'h4000, 2, 1, 1);
        push_elem(32'h2FFC, 32'h3FFE, 2, 1, 1);
        wr_reg(3, ctl(1, 0, 0, 0, 1, 1, 7, 6, 0, 2, 0));
        wait_idle();
        check("R3 byte accesses", 32'(exp_q.size()), 0);
        rd_reg(0, v); check("R4 src -4 steps", v, 32'h2FF8);
        rd_reg(1, v); check("R4 dst -2 steps", v, 32'h3FFC);
        check("R11 no irq without enable", 32'(irq), 0);
        wr_reg(3, 0);

        // R5 burst halfword, +1->+4, -1->-4
        setup(32'h5000, 32'h6000, 2);
        for (int i = 0; i < 8; i++) push_elem(32'h5000 + 4*i, 32'h6000 - 4*i, 1, 0, 1);
        wr_reg(3, ctl(1, 0, 1, 0, 0, 1, 1, 5, 0, 1, 0));
        wait_idle();
        check("R5 eight burst elements", 32'(exp_q.size()), 0);
        rd_reg(0, v); check("R5 src", v, 32'h5020);
        rd_reg(1, v); check("R5 dst", v, 32'h5FE0);
        rd_reg(2, v); check("R6 burst count zero", v, 0);
        wr_reg(3, 0);

        // R7 R8 handshake: src line 3, dst line 5
        setup(32'h7000, 32'h8000, 2);
        periph_req = 16'h0020;
        for (int i = 0; i < 16; i++) gnt_cnt[i] = 0;
        base = n_acc;
        wr_reg(3, ctl(1, 0, 0, 0, 0, 0, 3, 3, 5, 0, 3));
        repeat (20) @(negedge clk);
        check("R7 waits for request", 32'(n_acc - base), 0);
        wr_reg(0, 32'hDEAD_BEEF);
        rd_reg(0, v); check("R1 busy write ignored", v, 32'h7000);
        push_elem(32'h7000, 32'h8000, 0, 0, 0);
        push_elem(32'h7004, 32'h8004, 0, 0, 0);
        periph_req = 16'h0028;
        wait_idle();
        repeat (2) @(negedge clk);
        check("R7 accesses after request", 32'(exp_q.size()), 0);
        check("R8 grant src line", 32'(gnt_cnt[3]), 2);
        check("R8 grant dst line", 32'(gnt_cnt[5]), 2);
        begin
            int other = 0;
            for (int i = 0; i < 16; i++) if (i != 3 && i != 5) other += gnt_cnt[i];
            check("R8 no other grants", 32'(other), 0);
        end
        periph_req = '0;
        wr_reg(3, 0);

        // R9 error on first write
        setup(32'h9000, 32'hA000, 3);
        err_at = n_acc + 2;
        push(1'b0, 32'h9000, 0, 0, 0);
        push(1'b1, 32'hA000, 0, 0, pat(32'h9000));
        wr_reg(3, ctl(1, 0, 0, 1, 0, 0, 3, 3, 0, 0, 0));
        wait_idle();
        base = n_acc;
        repeat (20) @(negedge clk);
        check("R9 traffic stops", 32'(n_acc - base), 0);
        check("R9 expected accesses", 32'(exp_q.size()), 0);
        rd_reg(3, v); check("R9 err set, enable clear", v & 32'h13, 32'h10);
        rd_reg(2, v); check("R9 count frozen", v, 3);
        rd_reg(0, v); check("R9 src frozen", v, 32'h9000);
        check("R11 irq on error", 32'(irq), 1);
        wr_reg(3, ctl(0, 0, 0, 1, 0, 0, 3, 3, 0, 0, 0));
        rd_reg(3, v); check("R10 err cleared", 32'(v[4]), 0);
        check("R11 irq off", 32'(irq), 0);
        err_at = -1;

        // R12 stop while waiting
        setup(32'hB000, 32'hC000, 100);
        base = n_acc;
        wr_reg(3, ctl(1, 0, 0, 0, 0, 0, 3, 3, 0, 0, 2));
        repeat (10) @(negedge clk);
        wr_reg(3, ctl(0, 0, 0, 0, 0, 0, 3, 3, 0, 0, 2));
        periph_req = 16'h0004;
        repeat (30) @(negedge clk);
        check("R12 no accesses after stop", 32'(n_acc - base), 0);
        rd_reg(2, v); check("R12 count unchanged", v, 100);
        rd_reg(3, v); check("R12 stopped without done", v & 32'h3, 0);
        periph_req = '0;

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule